// File: doc/BRIEF.md
# Flash Erase and Write Control Registers

This block is the special-function-register front end that a small 8-bit controller uses to write and erase its on-chip program flash. Software programs a control register, a page-number register, a command register and a collision-flag register through a single byte-wide register write port. It reads them back through a separate combinational read port. Data-move writes from the core arrive on their own port. Depending on a write-enable bit, each one is either passed straight to data RAM or turned into a flash program request.

Erases are one-shot. A page erase runs only if the page register was written since the last page erase, and a mass erase runs only if its enable bit was set since the last mass erase. Both arming flags are consumed when their erase completes. Both are cleared when an erase command is refused. Every flash operation is presented to the flash macro as a request with an operation code, an address and a data byte. The request is held until the macro returns a done pulse, and the block reports itself busy over that whole span.

A sticky security bit masks the debug read path to zeros. Two collision flags record flash writes that overlap activity of the metering compute engine.

Top module: `flash_sfr_ctrl`

## Requirements
- R1: After reset, every readback register reads 0x00, `busy` and `fl_req` are low, and `fl_op` is 0.
- R2: While the write-enable bit (control bit 0) is 0, a data-move write asserts `ram_we` in the same cycle, with `ram_addr`/`ram_wdata` equal to the move's address and data, and raises no flash request.
- R3: While control bit 0 is 1 and the block is idle, a data-move write raises `fl_req` on the next cycle with `fl_op` = 1 (program), `fl_addr` equal to the move address and `fl_wdata` equal to the move data. It does not assert `ram_we`. Control bit 7 reads 1 while the operation runs.
- R4: Writing the page register (select 1, low PAGE_W bits) sets the page-armed flag (control bit 2). Writing command value 0xA5 (select 2) then raises `fl_req` with `fl_op` = 2 and `fl_addr` = page << (ADDR_W − PAGE_W).
- R5: A page-erase command issued without a fresh page-register write raises no request. The page-armed flag reads 0 after a page erase completes.
- R6: Writing 1 to control bit 1 sets the mass-armed flag (read back on bit 1). Command value 0x5A then raises `fl_req` with `fl_op` = 3 and `fl_addr` = 0. The flag is consumed on completion, so a repeated command raises nothing.
- R7: A command value other than 0xA5 or 0x5A changes nothing. A refused erase command (its own arm missing) clears both arming flags.
- R8: While busy, `fl_req`, `fl_op` and `fl_addr` stay fixed. Commands, arming writes and flash data-move writes are ignored. `busy` falls on the cycle after `fl_done` is seen.
- R9: The security bit (control bit 6) is set by writing 1, is unaffected by writing 0, and is cleared only by reset. While it is set, `dbg_rdata` is 0x00; otherwise it equals `fl_rdata`.
- R10: A flash program request issued while `ce_busy` is high sets flag bit 0 (select 3), and one issued while `ce_start` is high sets flag bit 1. Writing the flag register clears each bit written as 0 and leaves each bit written as 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 2 | Write register select: 0 control, 1 page, 2 command, 3 flags |
| sfr_wdata | input | 8 | Register write data |
| sfr_rsel | input | 2 | Read register select (same encoding) |
| sfr_rdata | output | 8 | Register read data |
| xw_en | input | 1 | Data-move write strobe from the core |
| xw_addr | input | ADDR_W | Data-pointer address of the move |
| xw_data | input | 8 | Accumulator byte of the move |
| ram_we | output | 1 | Data RAM write enable |
| ram_addr | output | ADDR_W | Data RAM address |
| ram_wdata | output | 8 | Data RAM write data |
| ce_busy | input | 1 | Compute engine is running a pass |
| ce_start | input | 1 | Compute engine is beginning a pass |
| fl_req | output | 1 | Flash operation request, held until done |
| fl_op | output | 2 | Operation: 0 none, 1 program, 2 page erase, 3 mass erase |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash program data |
| fl_done | input | 1 | One-cycle completion pulse from the flash macro |
| fl_rdata | input | 8 | Flash read data toward the debug port |
| dbg_rdata | output | 8 | Debug read data, masked when secured |
| busy | output | 1 | A flash operation is outstanding |

## Verification
The bench builds the block with its default parameters: a 16-bit address and 7-bit page number. With these, page 127 maps to byte address 0xFE00, so the highest page and the shift of the page number into the address are both in reach. A flash responder with a three-cycle latency keeps each operation busy long enough to issue commands, arming writes and flash data-move writes in the middle of it. A reset pulse part-way through the run makes the clearing of the sticky security bit observable.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PAGE  = 2'd2,
        OP_MASS  = 2'd3
    } fl_op_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_PAGE  = 2'd1;
    localparam logic [1:0] SEL_CMD   = 2'd2;
    localparam logic [1:0] SEL_FLAGS = 2'd3;

    localparam int CTRL_PWE    = 0;
    localparam int CTRL_MASS   = 1;
    localparam int CTRL_PAGEOK = 2;
    localparam int CTRL_SEC    = 6;
    localparam int CTRL_BUSY   = 7;

    localparam int FLAG_CEBUSY  = 0;
    localparam int FLAG_CESTART = 1;

endpackage

// File: rtl/flash_regs.sv
module flash_regs
    import flash_ctl_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [1:0]        sfr_sel,
    input  logic [7:0]        sfr_wdata,
    input  logic              busy,
    input  logic              wr_go,
    input  logic              ce_busy,
    input  logic              ce_start,
    output logic              pwe,
    output logic              secure,
    output logic [PAGE_W-1:0] page,
    output logic              col_busy,
    output logic              col_start
);

    typedef struct packed {
        logic              pwe;
        logic              secure;
        logic [PAGE_W-1:0] page;
        logic              col_busy;
        logic              col_start;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (sfr_we && sfr_sel == SEL_CTRL) begin
            regs_d.pwe = sfr_wdata[CTRL_PWE];
            if (sfr_wdata[CTRL_SEC]) begin
                regs_d.secure = 1'b1;
            end
        end
        if (sfr_we && sfr_sel == SEL_PAGE && !busy) begin
            regs_d.page = sfr_wdata[PAGE_W-1:0];
        end
        if (sfr_we && sfr_sel == SEL_FLAGS) begin
            regs_d.col_busy  = regs_q.col_busy  & sfr_wdata[FLAG_CEBUSY];
            regs_d.col_start = regs_q.col_start & sfr_wdata[FLAG_CESTART];
        end
        if (wr_go && ce_busy) begin
            regs_d.col_busy = 1'b1;
        end
        if (wr_go && ce_start) begin
            regs_d.col_start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pwe       = regs_q.pwe;
    assign secure    = regs_q.secure;
    assign page      = regs_q.page;
    assign col_busy  = regs_q.col_busy;
    assign col_start = regs_q.col_start;

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_ctl_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          PAGE_W   = 7,
    parameter logic [7:0]  CMD_PAGE = 8'hA5,
    parameter logic [7:0]  CMD_MASS = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_val,
    input  logic              page_wr,
    input  logic              mass_set,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] page,
    input  logic              fl_done,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              busy,
    output logic              page_ok,
    output logic              mass_ok
);

    localparam int SHIFT = ADDR_W - PAGE_W;

    typedef struct packed {
        logic              busy;
        fl_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              page_ok;
        logic              mass_ok;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (page_wr) begin
                seq_d.page_ok = 1'b1;
            end
            if (mass_set) begin
                seq_d.mass_ok = 1'b1;
            end
            if (cmd_wr && cmd_val == CMD_PAGE) begin
                if (seq_q.page_ok) begin
                    seq_d.busy  = 1'b1;
                    seq_d.op    = OP_PAGE;
                    seq_d.addr  = ADDR_W'(page) << SHIFT;
                    seq_d.wdata = '0;
                end else begin
                    seq_d.page_ok = 1'b0;
                    seq_d.mass_ok = 1'b0;
                end
            end else if (cmd_wr && cmd_val == CMD_MASS) begin
                if (seq_q.mass_ok) begin
                    seq_d.busy  = 1'b1;
                    seq_d.op    = OP_MASS;
                    seq_d.addr  = '0;
                    seq_d.wdata = '0;
                end else begin
                    seq_d.page_ok = 1'b0;
                    seq_d.mass_ok = 1'b0;
                end
            end else if (wr_go) begin
                seq_d.busy  = 1'b1;
                seq_d.op    = OP_WRITE;
                seq_d.addr  = wr_addr;
                seq_d.wdata = wr_data;
            end
        end else if (fl_done) begin
            seq_d.busy = 1'b0;
            seq_d.op   = OP_NONE;
            if (seq_q.op == OP_PAGE) begin
                seq_d.page_ok = 1'b0;
            end
            if (seq_q.op == OP_MASS) begin
                seq_d.mass_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{busy: 1'b0, op: OP_NONE, addr: '0, wdata: '0,
                       page_ok: 1'b0, mass_ok: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fl_req   = seq_q.busy;
    assign busy     = seq_q.busy;
    assign fl_op    = seq_q.op;
    assign fl_addr  = seq_q.addr;
    assign fl_wdata = seq_q.wdata;
    assign page_ok  = seq_q.page_ok;
    assign mass_ok  = seq_q.mass_ok;

endmodule

// File: rtl/flash_sfr_ctrl.sv
module flash_sfr_ctrl
    import flash_ctl_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         PAGE_W   = 7,
    parameter logic [7:0] CMD_PAGE = 8'hA5,
    parameter logic [7:0] CMD_MASS = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [1:0]        sfr_sel,
    input  logic [7:0]        sfr_wdata,
    input  logic [1:0]        sfr_rsel,
    output logic [7:0]        sfr_rdata,
    input  logic              xw_en,
    input  logic [ADDR_W-1:0] xw_addr,
    input  logic [7:0]        xw_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic              ce_busy,
    input  logic              ce_start,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic              fl_done,
    input  logic [7:0]        fl_rdata,
    output logic [7:0]        dbg_rdata,
    output logic              busy
);

    logic              pwe;
    logic              secure;
    logic [PAGE_W-1:0] page;
    logic              col_busy;
    logic              col_start;
    logic              page_ok;
    logic              mass_ok;
    logic              cmd_wr;
    logic              page_wr;
    logic              mass_set;
    logic              wr_go;

    assign cmd_wr   = sfr_we && sfr_sel == SEL_CMD;
    assign page_wr  = sfr_we && sfr_sel == SEL_PAGE;
    assign mass_set = sfr_we && sfr_sel == SEL_CTRL && sfr_wdata[CTRL_MASS];
    assign wr_go    = xw_en && pwe && !busy && !cmd_wr;

    flash_regs #(
        .PAGE_W (PAGE_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_we    (sfr_we),
        .sfr_sel   (sfr_sel),
        .sfr_wdata (sfr_wdata),
        .busy      (busy),
        .wr_go     (wr_go),
        .ce_busy   (ce_busy),
        .ce_start  (ce_start),
        .pwe       (pwe),
        .secure    (secure),
        .page      (page),
        .col_busy  (col_busy),
        .col_start (col_start)
    );

    flash_seq #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .CMD_PAGE (CMD_PAGE),
        .CMD_MASS (CMD_MASS)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_val  (sfr_wdata),
        .page_wr  (page_wr),
        .mass_set (mass_set),
        .wr_go    (wr_go),
        .wr_addr  (xw_addr),
        .wr_data  (xw_data),
        .page     (page),
        .fl_done  (fl_done),
        .fl_req   (fl_req),
        .fl_op    (fl_op),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .busy     (busy),
        .page_ok  (page_ok),
        .mass_ok  (mass_ok)
    );

    assign ram_we    = xw_en && !pwe;
    assign ram_addr  = xw_addr;
    assign ram_wdata = xw_data;
    assign dbg_rdata = secure ? 8'h00 : fl_rdata;

    always_comb begin
        sfr_rdata = 8'h00;
        case (sfr_rsel)
            SEL_CTRL: begin
                sfr_rdata[CTRL_PWE]    = pwe;
                sfr_rdata[CTRL_MASS]   = mass_ok;
                sfr_rdata[CTRL_PAGEOK] = page_ok;
                sfr_rdata[CTRL_SEC]    = secure;
                sfr_rdata[CTRL_BUSY]   = busy;
            end
            SEL_PAGE:  sfr_rdata[PAGE_W-1:0] = page;
            SEL_FLAGS: begin
                sfr_rdata[FLAG_CEBUSY]  = col_busy;
                sfr_rdata[FLAG_CESTART] = col_start;
            end
            default:   sfr_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_sfr_ctrl_chk.sv
module flash_sfr_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fl_req,
    input logic              fl_done,
    input logic [1:0]        fl_op,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              secure,
    input logic              page_ok,
    input logic              mass_ok
);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_done |=> fl_req && $stable(fl_addr) && $stable(fl_op));

    p_req_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && fl_done |=> !fl_req);

    p_secure_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        secure |=> secure);

    p_page_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) && fl_op == 2'd2 |-> $past(page_ok));

    p_mass_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) && fl_op == 2'd3 |-> $past(mass_ok));

    p_page_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && fl_done && fl_op == 2'd2 |=> !page_ok);

endmodule

bind flash_sfr_ctrl flash_sfr_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fl_req  (fl_req),
    .fl_done (fl_done),
    .fl_op   (fl_op),
    .fl_addr (fl_addr),
    .secure  (secure),
    .page_ok (page_ok),
    .mass_ok (mass_ok)
);

// File: tb/test_flash_sfr_ctrl.sv
module test_flash_sfr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DONE_LAT   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sfr_we = 1'b0;
    logic [1:0]        sfr_sel = 2'd0;
    logic [7:0]        sfr_wdata = 8'h00;
    logic [1:0]        sfr_rsel = 2'd0;
    logic [7:0]        sfr_rdata;
    logic              xw_en = 1'b0;
    logic [ADDR_W-1:0] xw_addr = '0;
    logic [7:0]        xw_data = 8'h00;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic              ce_busy = 1'b0;
    logic              ce_start = 1'b0;
    logic              fl_req;
    logic [1:0]        fl_op;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0]        fl_wdata;
    logic              fl_done;
    logic [7:0]        fl_rdata = 8'hC3;
    logic [7:0]        dbg_rdata;
    logic              busy;

    int checks = 0;
    int errors = 0;
    int lat_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sfr_ctrl i_flash_sfr_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_sel(sfr_sel),
        .sfr_wdata(sfr_wdata), .sfr_rsel(sfr_rsel), .sfr_rdata(sfr_rdata),
        .xw_en(xw_en), .xw_addr(xw_addr), .xw_data(xw_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ce_busy(ce_busy), .ce_start(ce_start), .fl_req(fl_req),
        .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_done(fl_done), .fl_rdata(fl_rdata), .dbg_rdata(dbg_rdata),
        .busy(busy)
    );

    // flash macro stand-in: done pulse DONE_LAT cycles into a request
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_done <= 1'b0;
            lat_cnt <= 0;
        end else if (fl_req && !fl_done) begin
            if (lat_cnt == DONE_LAT - 1) begin
                fl_done <= 1'b1;
                lat_cnt <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            fl_done <= 1'b0;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic sfr_write(logic [1:0] sel, logic [7:0] data);
        sfr_we = 1'b1; sfr_sel = sel; sfr_wdata = data;
        @(posedge clk); @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic sfr_read(logic [1:0] sel, output logic [7:0] val);
        sfr_rsel = sel;
        #1;
        val = sfr_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        sfr_read(2'd0, v); check("R1", "ctrl", v, 8'h00);
        sfr_read(2'd1, v); check("R1", "page", v, 8'h00);
        sfr_read(2'd3, v); check("R1", "flags", v, 8'h00);
        check("R1", "busy", busy, 1'b0);
        check("R1", "fl_req", fl_req, 1'b0);
        check("R1", "fl_op", fl_op, 2'd0);
    endtask

    task automatic t_ram_path();
        sfr_write(2'd0, 8'h00);
        xw_en = 1'b1; xw_addr = 16'h0042; xw_data = 8'h99;
        #1;
        check("R2", "ram_we", ram_we, 1'b1);
        check("R2", "ram_addr", ram_addr, 16'h0042);
        check("R2", "ram_wdata", ram_wdata, 8'h99);
        @(posedge clk); @(negedge clk);
        xw_en = 1'b0;
        check("R2", "no fl_req", fl_req, 1'b0);
    endtask

    task automatic t_flash_write();
        logic [7:0] v;
        sfr_write(2'd0, 8'h01);
        xw_en = 1'b1; xw_addr = 16'h1234; xw_data = 8'h5A;
        #1;
        check("R3", "ram_we low", ram_we, 1'b0);
        @(posedge clk); @(negedge clk);
        xw_en = 1'b0;
        check("R3", "fl_req", fl_req, 1'b1);
        check("R3", "fl_op", fl_op, 2'd1);
        check("R3", "fl_addr", fl_addr, 16'h1234);
        check("R3", "fl_wdata", fl_wdata, 8'h5A);
        sfr_read(2'd0, v); check("R3", "ctrl busy bit", v[7], 1'b1);
        wait_idle();
        sfr_write(2'd0, 8'h00);
    endtask

    task automatic t_page_erase();
        logic [7:0] v;
        sfr_write(2'd1, 8'd127);
        sfr_read(2'd0, v); check("R4", "page armed", v[2], 1'b1);
        sfr_read(2'd1, v); check("R4", "page readback", v, 8'd127);
        sfr_write(2'd2, 8'hA5);
        check("R4", "fl_req", fl_req, 1'b1);
        check("R4", "fl_op", fl_op, 2'd2);
        check("R4", "fl_addr", fl_addr, 16'hFE00);
        wait_idle();
        sfr_read(2'd0, v); check("R5", "page arm consumed", v[2], 1'b0);
        sfr_write(2'd2, 8'hA5);
        check("R5", "stale page refused", fl_req, 1'b0);
    endtask

    task automatic t_mass_erase();
        logic [7:0] v;
        sfr_write(2'd0, 8'h02);
        sfr_read(2'd0, v); check("R6", "mass armed", v[1], 1'b1);
        sfr_write(2'd2, 8'h5A);
        check("R6", "fl_req", fl_req, 1'b1);
        check("R6", "fl_op", fl_op, 2'd3);
        check("R6", "fl_addr", fl_addr, 16'h0000);
        wait_idle();
        sfr_read(2'd0, v); check("R6", "mass arm consumed", v[1], 1'b0);
        sfr_write(2'd2, 8'h5A);
        check("R6", "repeat refused", fl_req, 1'b0);
    endtask

    task automatic t_reject();
        logic [7:0] v;
        sfr_write(2'd0, 8'h02);
        sfr_write(2'd2, 8'h33);
        check("R7", "odd cmd no req", fl_req, 1'b0);
        sfr_read(2'd0, v); check("R7", "odd cmd keeps arm", v[1], 1'b1);
        sfr_write(2'd2, 8'hA5);
        check("R7", "unarmed page no req", fl_req, 1'b0);
        sfr_read(2'd0, v); check("R7", "refusal clears mass arm", v[1], 1'b0);
        sfr_write(2'd2, 8'h5A);
        check("R7", "mass after refusal", fl_req, 1'b0);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        sfr_write(2'd0, 8'h02);
        sfr_write(2'd1, 8'd5);
        sfr_write(2'd2, 8'hA5);
        check("R8", "page req", fl_op, 2'd2);
        check("R8", "page addr", fl_addr, 16'h0A00);
        sfr_write(2'd2, 8'h5A);
        check("R8", "op held", fl_op, 2'd2);
        check("R8", "addr held", fl_addr, 16'h0A00);
        sfr_write(2'd1, 8'd9);
        sfr_read(2'd1, v); check("R8", "page write ignored", v, 8'd5);
        for (int i = 0; i < 20 && !fl_done; i++) @(negedge clk);
        check("R8", "busy at done", busy, 1'b1);
        @(negedge clk);
        check("R8", "busy after done", busy, 1'b0);
        sfr_read(2'd0, v); check("R8", "mass arm kept", v[1], 1'b1);
        @(negedge clk);
        check("R8", "no late req", fl_req, 1'b0);
        sfr_write(2'd2, 8'h5A);
        wait_idle();
    endtask

    task automatic t_collision();
        logic [7:0] v;
        sfr_write(2'd0, 8'h01);
        xw_en = 1'b1; xw_addr = 16'h0010; xw_data = 8'h01;
        @(posedge clk); @(negedge clk); xw_en = 1'b0;
        sfr_read(2'd3, v); check("R10", "no collision", v, 8'h00);
        wait_idle();
        ce_busy = 1'b1; xw_en = 1'b1;
        @(posedge clk); @(negedge clk); xw_en = 1'b0; ce_busy = 1'b0;
        sfr_read(2'd3, v); check("R10", "busy collision", v, 8'h01);
        wait_idle();
        ce_start = 1'b1; xw_en = 1'b1;
        @(posedge clk); @(negedge clk); xw_en = 1'b0; ce_start = 1'b0;
        sfr_read(2'd3, v); check("R10", "start collision", v, 8'h03);
        wait_idle();
        sfr_write(2'd3, 8'h02);
        sfr_read(2'd3, v); check("R10", "clear bit0 only", v, 8'h02);
        sfr_write(2'd3, 8'h00);
        sfr_read(2'd3, v); check("R10", "clear all", v, 8'h00);
        sfr_write(2'd0, 8'h00);
    endtask

    task automatic t_secure();
        logic [7:0] v;
        #1; check("R9", "dbg open", dbg_rdata, 8'hC3);
        sfr_write(2'd0, 8'h40);
        sfr_read(2'd0, v); check("R9", "secure set", v[6], 1'b1);
        check("R9", "dbg masked", dbg_rdata, 8'h00);
        sfr_write(2'd0, 8'h00);
        sfr_read(2'd0, v); check("R9", "zero write ignored", v[6], 1'b1);
        check("R9", "dbg still masked", dbg_rdata, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sfr_read(2'd0, v); check("R9", "reset clears", v[6], 1'b0);
        check("R9", "dbg after reset", dbg_rdata, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ram_path();
        t_flash_write();
        t_page_erase();
        t_mass_erase();
        t_reject();
        t_busy();
        t_collision();
        t_secure();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule